// File: doc/BRIEF.md
# Divided Sample Clock Phase Aligner

This block produces the sampling strobe for a converter core. It runs as a clock-enable generator in the input-clock domain. A configuration bit picks one of two rates. At the full rate the core samples on every input-clock cycle. At half rate an internal divided clock is formed, and sampling falls on its falling transition, so the strobe is high on every second cycle.

In half-rate mode a phase bit inverts the divided clock. This moves the sampling cycle by one input period, which lets several converters that share one input clock be brought into step after skew on their control paths. A new rate or phase request is held back until the next point where the divided clock is about to fall. A phase change therefore always stretches the high half of the divided clock and never squeezes two strobes together.

A synchronous reset loads the requested settings and starts the divider in a fixed state. Two instances reset on the same edge with the same settings then strobe on the same cycles. The pins are plain control and status signals: there is no data stream, so no valid/ready handshake and no back-pressure applies.

Top module: `sample_phase_aligner`

## Requirements
- R1: While full rate is in effect (`div2_sel` committed as 0), `samp_en` is 1 on every cycle and `div_clk` is 0.
- R2: While half rate is in effect with a steady phase, `div_clk` alternates every cycle and `samp_en` is 1 exactly on the cycles where `div_clk` is 0, so `samp_en` is never high on two consecutive cycles.
- R3: On the first cycle after reset is released with half rate requested, `samp_en` is 1 and `div_clk` is 0 when `phase_sel` is 0; `samp_en` is 0 and `div_clk` is 1 when `phase_sel` is 1.
- R4: In half rate, a committed change of the phase bit keeps `div_clk` at 1 for two consecutive cycles. The gap between the strobes on either side of the change is therefore three cycles: the sampling point moves later by exactly one input cycle.
- R5: A change of `div2_sel` or `phase_sel` is committed only at a clock edge that ends a cycle in which the internal divided level is 1. A request made while that level is 0 waits one cycle before it is committed.
- R6: While full rate is in effect, toggling `phase_sel` has no effect on `samp_en` (held at 1) or on `div_clk` (held at 0).
- R7: `rst` is synchronous and active high. It loads the requested settings and clears the divider, so that two instances reset on the same edge with the same settings produce identical `samp_en` and `div_clk` from then on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| div2_sel | input | 1 | Rate request: 0 full rate, 1 half rate |
| phase_sel | input | 1 | Phase request: 1 inverts the divided clock in half rate |
| samp_en | output | 1 | Sample strobe, one input cycle wide per sample |
| div_clk | output | 1 | Level of the internal divided clock (0 at full rate) |

## Verification
A divider that is out of step shows on the first cycle after reset: `samp_en` lands on the wrong parity, and a second instance reset alongside disagrees at once. A committed setting that is latched at the wrong moment shows one cycle later, either as two back-to-back strobes in half rate or as a strobe gap of two or four cycles instead of three around a phase change. A phase bit that leaks into full-rate mode shows as a dropped strobe on the very cycle it is toggled.

// File: rtl/spa_pkg.sv
package spa_pkg;

  typedef struct packed {
    logic half_rate;
    logic invert;
  } spa_cfg_t;

  localparam spa_cfg_t SPA_CFG_FULL = '{half_rate: 1'b0, invert: 1'b0};

  function automatic logic spa_level(input logic tog, input spa_cfg_t cfg);
    return tog ^ cfg.invert;
  endfunction

endpackage

// File: rtl/spa_toggle.sv
module spa_toggle (
  input  logic clk,
  input  logic rst,
  output logic tog
);

  always_ff @(posedge clk) begin
    if (rst) tog <= 1'b0;
    else     tog <= ~tog;
  end

  // R7: free-running divider flips every cycle once out of reset
  p_toggle_runs_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (tog != $past(tog)));

endmodule

// File: rtl/spa_cfg_commit.sv
module spa_cfg_commit
  import spa_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  spa_cfg_t req,
  input  logic     level,
  output spa_cfg_t cur
);

  always_ff @(posedge clk) begin
    if (rst)        cur <= req;
    else if (level) cur <= req;
  end

  // R5: committed settings move only after a cycle with level high
  p_commit_point_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(cur)) |-> $past(level));

endmodule

// File: rtl/spa_strobe.sv
module spa_strobe
  import spa_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     tog,
  input  spa_cfg_t cur,
  output logic     level,
  output logic     samp_en,
  output logic     div_clk
);

  always_comb begin
    level = spa_level(tog, cur);
    if (cur.half_rate) begin
      div_clk = level;
      samp_en = ~level;
    end else begin
      div_clk = 1'b0;
      samp_en = 1'b1;
    end
  end

  // R1: full rate strobes every cycle with the divided clock parked low
  p_full_rate_r1: assert property (@(posedge clk) disable iff (rst)
    (!cur.half_rate && !$past(rst) && !$past(cur.half_rate))
      |-> (samp_en && $past(samp_en) && !div_clk));

  // R2: no two strobes in a row while half rate stays in effect
  p_no_back_to_back_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && cur.half_rate && $past(cur.half_rate) && $past(samp_en))
      |-> !samp_en);

  // R4: a phase flip stretches the high half rather than adding a strobe
  p_phase_stretch_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && cur.half_rate && $past(cur.half_rate) && !$stable(cur.invert))
      |-> (div_clk && $past(div_clk)));

endmodule

// File: rtl/sample_phase_aligner.sv
module sample_phase_aligner
  import spa_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic div2_sel,
  input  logic phase_sel,
  output logic samp_en,
  output logic div_clk
);

  logic     tog;
  logic     level;
  spa_cfg_t req;
  spa_cfg_t cur;

  assign req = '{half_rate: div2_sel, invert: phase_sel};

  spa_toggle u_toggle (
    .clk (clk),
    .rst (rst),
    .tog (tog)
  );

  spa_cfg_commit u_commit (
    .clk   (clk),
    .rst   (rst),
    .req   (req),
    .level (level),
    .cur   (cur)
  );

  spa_strobe u_strobe (
    .clk     (clk),
    .rst     (rst),
    .tog     (tog),
    .cur     (cur),
    .level   (level),
    .samp_en (samp_en),
    .div_clk (div_clk)
  );

endmodule

// File: tb/sample_phase_aligner_test.sv
module sample_phase_aligner_test;

  logic clk = 1'b0;
  logic rst_a = 1'b1, rst_b = 1'b1;
  logic d_a = 1'b1, p_a = 1'b0, d_b = 1'b1, p_b = 1'b0;
  logic en_a, ck_a, en_b, ck_b;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  always #10ns clk = ~clk;

  sample_phase_aligner uut (
    .clk(clk), .rst(rst_a), .div2_sel(d_a), .phase_sel(p_a),
    .samp_en(en_a), .div_clk(ck_a));

  sample_phase_aligner uut_b (
    .clk(clk), .rst(rst_b), .div2_sel(d_b), .phase_sel(p_b),
    .samp_en(en_b), .div_clk(ck_b));

  // each entry: {div2_sel, phase_sel, expected samp_en, expected div_clk}
  localparam int NV = 20;
  localparam logic [3:0] VEC [NV] = '{
    4'b1010, 4'b1001, 4'b1110, 4'b1101, 4'b1101,
    4'b1110, 4'b1101, 4'b1010, 4'b1001, 4'b1001,
    4'b0010, 4'b0001, 4'b0010, 4'b0110, 4'b0110,
    4'b1110, 4'b1110, 4'b1110, 4'b1101, 4'b1110};

  task automatic check(input string req, input logic en_x, input logic ck_x,
                       input logic en_e, input logic ck_e);
    n_chk++;
    if (en_x !== en_e || ck_x !== ck_e) begin
      n_bad++;
      $display("FAIL %s: samp_en/div_clk = %b/%b, expected %b/%b",
               req, en_x, ck_x, en_e, ck_e);
    end
  endtask

  initial begin
    #(20ns * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_a = 1'b0; rst_b = 1'b0;
    // R3: half rate, phase 0 -> strobe on the first cycle after reset
    check("R3", en_a, ck_a, 1'b1, 1'b0);

    // table: R2 alternation, R4 phase shift, R5 deferred commit, R1 full rate
    for (int k = 0; k < NV; k++) begin
      string tag;
      if (k < 10)      tag = "R2/R4/R5 half-rate phase moves";
      else if (k < 15) tag = "R1/R6 full rate";
      else             tag = "R5 return to half rate";
      check(tag, en_a, ck_a, VEC[k][1], VEC[k][0]);
      d_a = VEC[k][3]; p_a = VEC[k][2];
      @(negedge clk);
    end

    // R3: reset with phase 1 -> first cycle has no strobe
    rst_a = 1'b1; rst_b = 1'b1;
    d_a = 1'b1; p_a = 1'b1; d_b = 1'b1; p_b = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst_a = 1'b0; rst_b = 1'b0;
    check("R3 inverted start", en_a, ck_a, 1'b0, 1'b1);
    // R7: two instances reset together stay in step
    for (int k = 0; k < 6; k++) begin
      check("R7 instances aligned", en_b, ck_b, en_a, ck_a);
      check("R7 parity after reset", en_a, ck_a, logic'(k % 2), logic'(1 - k % 2));
      @(negedge clk);
    end

    // R6: full rate with phase toggled every cycle
    rst_a = 1'b1; d_a = 1'b0; p_a = 1'b0;
    @(negedge clk);
    rst_a = 1'b0;
    for (int k = 0; k < 8; k++) begin
      check("R6 phase ignored at full rate", en_a, ck_a, 1'b1, 1'b0);
      p_a = ~p_a;
      @(negedge clk);
    end

    // R5: half-rate request made while the level is low waits a cycle
    rst_a = 1'b1; d_a = 1'b1; p_a = 1'b0;
    @(negedge clk);
    rst_a = 1'b0;                 // cycle 0: level low, strobe
    check("R5 start", en_a, ck_a, 1'b1, 1'b0);
    d_a = 1'b0;                   // request full rate while level low
    @(negedge clk);               // cycle 1: still half rate, level high
    check("R5 request held", en_a, ck_a, 1'b0, 1'b1);
    @(negedge clk);               // cycle 2: full rate now in effect
    check("R5 committed", en_a, ck_a, 1'b1, 1'b0);
    @(negedge clk);
    check("R1 full rate steady", en_a, ck_a, 1'b1, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule